// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits between an execution unit and code memory. A fetch engine reads instruction bytes ahead of need, using fixed four-clock read cycles on a request/ready memory port. The returned bytes go into a small circular queue. The execution unit takes them from the head one at a time. A flush with a target address (a taken branch) empties the queue, drops any read that is still in flight, and restarts fetching at the target.

A parameter picks the memory path width. On the narrow path each read returns one byte. On the wide path a read at an even address returns two bytes. A read at an odd address returns only the upper byte, and fetching then continues at the next even address.

The fetch engine is a five-state machine: `FS_IDLE` (no room, waiting), `FS_T1` (address phase, request pulsed), `FS_T2` and `FS_T3` (bus busy), `FS_T4` (data phase, bytes accepted when ready). Its transitions are:
- start: `FS_IDLE`→`FS_T1` when there is room.
- advance: `FS_T1`→`FS_T2`→`FS_T3`→`FS_T4`.
- chain: `FS_T4`→`FS_T1` on ready when room remains.
- park: `FS_T4`→`FS_IDLE` on ready when the queue is full.
- hold: `FS_T4`→`FS_T4` while ready is low.

Top module: `ifq_unit`

## Requirements
- R1: While reset is held, `q_valid` and `mem_req` are low. The first read after reset uses the address `START_ADDR` (default 0).
- R2: A read cycle lasts four clocks. `mem_req` is high for the single first clock, with `mem_addr` valid. Data is taken at the end of the fourth clock, when `mem_rdy` is high. With room available, the first byte of a read is visible on `q_valid`/`q_byte` four clocks after the clock in which `mem_req` was high.
- R3: With the narrow path (`WIDE`=0), each read returns exactly one byte on `mem_rdata[7:0]`, and the fetch address then advances by one (modulo 2^AW).
- R4: The engine starts a read whenever the queue has room, with no pop requested. It stops once `DEPTH` bytes are held, and the occupancy never exceeds `DEPTH`.
- R5: Bytes leave in fetch-address order. `q_byte` is the head byte whenever `q_valid` is high. A pop while `q_valid` is low has no effect.
- R6: Once the last held byte is popped, `q_valid` stays low until the next fetched byte arrives.
- R7: A flush empties the queue at the next clock. The next read uses `flush_addr`, and the bytes that follow start from that address.
- R8: A read in flight when a flush occurs still runs to completion on the bus, but its data never enters the queue.
- R9: With the wide path (`WIDE`=1), a read at an even address queues `mem_rdata[7:0]` (even byte) first and then `mem_rdata[15:8]`. The address advances by two.
- R10: With the wide path, a read at an odd address queues only `mem_rdata[15:8]`. The address then advances by one, to the next even address.
- R11: With the wide path, a read starts only when at least two entries are free, or one entry for an odd address.
- R12: A pop and a push in the same clock are both accepted. The occupancy changes by the net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | output | 1 | Head byte present |
| q_byte | output | 8 | Head byte of the queue |
| q_pop | input | 1 | Consume the head byte |
| flush | input | 1 | Discard queue and in-flight read, redirect fetching |
| flush_addr | input | AW | New fetch address used with `flush` |
| mem_req | output | 1 | Read cycle start (address phase) |
| mem_addr | output | AW | Byte address of the read |
| mem_rdy | input | 1 | Read data valid (fourth clock of the cycle) |
| mem_rdata | input | 16 | Read data; narrow path uses bits 7:0 |

## Verification
The hardest situations to reach from the ports are two:
- A flush that lands while a read is mid-cycle.
- On the wide path, the state where exactly one entry is free in front of an even fetch address.

For the first, the bench watches `mem_req` and flushes one clock later, in the second bus clock. It then checks that the next request carries the new target and that the abandoned byte never appears. For the second, the bench flushes the wide instance to an odd target and lets it fill with no pops. The queue ends with one slot open, and the bench checks that no further request appears. A single pop must then release exactly one more read.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_T1,
        FS_T2,
        FS_T3,
        FS_T4
    } fstate_e;
endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic          pop,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    data_q [DEPTH];
    logic [IW-1:0] wr_q, rd_q;
    logic          pop_ok;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] i, input logic [1:0] k);
        logic [IW:0] s;
        s = {1'b0, i} + (IW+1)'(k);
        if (s >= (IW+1)'(DEPTH)) s = s - (IW+1)'(DEPTH);
        return s[IW-1:0];
    endfunction

    always_comb begin
        pop_ok    = pop && (cnt_q != '0) && !clear;
        cnt_nxt   = clear ? '0 : (cnt_q + CW'(push_n) - CW'(pop_ok));
        out_valid = (cnt_q != '0);
        out_byte  = data_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (push_n != 2'd0) wr_q <= step(wr_q, push_n);
            if (pop_ok)         rd_q <= step(rd_q, 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) data_q[wr_q] <= push_b0;
        if (push_n == 2'd2) data_q[step(wr_q, 2'd1)] <= push_b1;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && !out_valid));

    // R5
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !clear && push_n == 2'd0) |=> (cnt_q == '0));

    // R12
    net_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0 && pop && cnt_q != '0 && !clear)
        |=> (cnt_q == $past(cnt_q) + CW'($past(push_n)) - CW'(1)));
endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch
    import ifq_pkg::*;
#(
    parameter int          AW         = 20,
    parameter int          DEPTH      = 4,
    parameter int          CW         = 3,
    parameter bit          WIDE       = 1'b0,
    parameter logic [AW-1:0] START_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          mem_rdy,
    input  logic [15:0]   mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    push_n,
    output logic [7:0]    push_b0,
    output logic [7:0]    push_b1
);
    fstate_e       state_q, state_nxt;
    logic [AW-1:0] addr_q, addr_nxt;
    logic          discard_q, discard_nxt;
    logic          done, take, room;
    logic [CW:0]   free_nxt, free_now;

    function automatic logic [1:0] need_of(input logic a0);
        return (WIDE && !a0) ? 2'd2 : 2'd1;
    endfunction

    always_comb begin
        done = (state_q == FS_T4) && mem_rdy;
        take = done && !discard_q && !flush;
        if (flush)     addr_nxt = flush_addr;
        else if (take) addr_nxt = addr_q + AW'(need_of(addr_q[0]));
        else           addr_nxt = addr_q;
        free_nxt = (CW+1)'(DEPTH) - {1'b0, cnt_nxt};
        free_now = (CW+1)'(DEPTH) - {1'b0, cnt_q};
        room     = free_nxt >= (CW+1)'(need_of(addr_nxt[0]));
        if (flush)     discard_nxt = (state_q != FS_IDLE) && !done;
        else if (done) discard_nxt = 1'b0;
        else           discard_nxt = discard_q;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            FS_IDLE: state_nxt = room ? FS_T1 : FS_IDLE;
            FS_T1:   state_nxt = FS_T2;
            FS_T2:   state_nxt = FS_T3;
            FS_T3:   state_nxt = FS_T4;
            FS_T4:   if (mem_rdy) state_nxt = room ? FS_T1 : FS_IDLE;
            default: state_nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FS_IDLE;
            addr_q    <= START_ADDR;
            discard_q <= 1'b0;
        end else begin
            state_q   <= state_nxt;
            addr_q    <= addr_nxt;
            discard_q <= discard_nxt;
        end
    end

    always_comb begin
        mem_req  = (state_q == FS_T1);
        mem_addr = addr_q;
        push_n   = take ? need_of(addr_q[0]) : 2'd0;
    end

    generate
        if (WIDE) begin : g_wide
            assign push_b0 = addr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
            assign push_b1 = mem_rdata[15:8];
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^mem_rdata[15:8];
            assign push_b0   = mem_rdata[7:0];
            assign push_b1   = 8'h00;
        end
    endgenerate

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R2
    read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req, 3));

    // R8
    no_stale_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (push_n == 2'd0));

    // R11
    room_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (free_now >= (CW+1)'(need_of(addr_q[0]))));
endmodule

// File: rtl/ifq_unit.sv
module ifq_unit #(
    parameter int            AW         = 20,
    parameter int            DEPTH      = 4,
    parameter bit            WIDE       = 1'b0,
    parameter logic [AW-1:0] START_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          q_valid,
    output logic [7:0]    q_byte,
    input  logic          q_pop,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rdy,
    input  logic [15:0]   mem_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]    push_n;
    logic [7:0]    push_b0, push_b1;
    logic [CW-1:0] cnt_q, cnt_nxt;

    ifq_fetch #(
        .AW(AW), .DEPTH(DEPTH), .CW(CW), .WIDE(WIDE), .START_ADDR(START_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .flush_addr(flush_addr),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
    );

    ifq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .clear(flush),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop(q_pop),
        .out_valid(q_valid), .out_byte(q_byte),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
    );
endmodule

// File: tb/ifq_unit_tb.sv
`timescale 1ns/1ps
module ifq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pop_s   [2];
    logic        flush_s [2];
    logic [19:0] ftgt_s  [2];
    logic        val_w   [2];
    logic [7:0]  byte_w  [2];
    logic        req_w   [2];
    logic [19:0] addr_w  [2];
    logic        rdy_w   [2];
    logic [15:0] rdata_w [2];
    logic [1:0]  ph      [2];
    logic [19:0] la      [2];
    int          reqs    [2];
    logic [19:0] last_a  [2];
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Case table: flush target, bytes to pop (narrow instance)
    localparam int NV = 5;
    localparam logic [19:0] V_TGT [NV] = '{20'h00100, 20'h0ABCD, 20'h7FFFE, 20'hFFFFE, 20'h12345};
    localparam int          V_POP [NV] = '{3, 5, 2, 4, 6};

    always #2.5 clk = ~clk;

    ifq_unit #(.AW(20), .DEPTH(4), .WIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .q_valid(val_w[0]), .q_byte(byte_w[0]), .q_pop(pop_s[0]),
        .flush(flush_s[0]), .flush_addr(ftgt_s[0]), .mem_req(req_w[0]), .mem_addr(addr_w[0]),
        .mem_rdy(rdy_w[0]), .mem_rdata(rdata_w[0]));

    ifq_unit #(.AW(20), .DEPTH(6), .WIDE(1'b1)) u_wide (
        .clk(clk), .rst_n(rst_n), .q_valid(val_w[1]), .q_byte(byte_w[1]), .q_pop(pop_s[1]),
        .flush(flush_s[1]), .flush_addr(ftgt_s[1]), .mem_req(req_w[1]), .mem_addr(addr_w[1]),
        .mem_rdy(rdy_w[1]), .mem_rdata(rdata_w[1]));

    function automatic logic [7:0] bval(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                ph[i] <= 2'd0;
                reqs[i] <= 0;
            end else begin
                if (req_w[i]) begin
                    ph[i] <= 2'd1;
                    la[i] <= addr_w[i];
                    reqs[i] <= reqs[i] + 1;
                    last_a[i] <= addr_w[i];
                end else if (ph[i] != 2'd0) begin
                    ph[i] <= ph[i] + 2'd1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            rdy_w[i] = (ph[i] == 2'd3);
            if (i == 1) rdata_w[i] = {bval(la[i] | 20'h1), bval(la[i] & ~20'h1)};
            else        rdata_w[i] = {8'h00, bval(la[i])};
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_chk(input int i, input logic [19:0] a, input string rq);
        int t = 0;
        while (!val_w[i] && t < 100) begin @(negedge clk); t++; end
        chk(rq, {24'h0, byte_w[i]}, {24'h0, bval(a)});
        pop_s[i] = 1'b1;
        @(negedge clk);
        pop_s[i] = 1'b0;
    endtask

    task automatic do_flush(input int i, input logic [19:0] a);
        flush_s[i] = 1'b1;
        ftgt_s[i]  = a;
        @(negedge clk);
        flush_s[i] = 1'b0;
    endtask

    task automatic wait_req(input int i, input int base);
        int t = 0;
        while (reqs[i] == base && t < 100) begin @(negedge clk); t++; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int k;
        int base;
        for (int i = 0; i < 2; i++) begin
            pop_s[i] = 1'b0; flush_s[i] = 1'b0; ftgt_s[i] = '0;
        end
        idle(3);
        // R1: reset state
        chk("R1 valid in reset", {31'h0, val_w[0]}, 0);
        chk("R1 wide valid in reset", {31'h0, val_w[1]}, 0);
        chk("R1 req in reset", {31'h0, req_w[0]}, 0);
        rst_n = 1'b1;

        // R1/R2: first read address and latency
        k = 0;
        while (!req_w[0] && k < 20) begin @(negedge clk); k++; end
        chk("R1 first read address", {12'h0, addr_w[0]}, 0);
        k = 0;
        while (!val_w[0] && k < 20) begin @(negedge clk); k++; end
        chk("R2 first byte latency", k, 4);

        // R4/R11: run ahead with no pops, stop when full
        idle(40);
        chk("R4 narrow fill reads", reqs[0], 4);
        chk("R11 wide fill reads", reqs[1], 3);

        // R3/R5/R6: drain in order, then empty
        for (int j = 0; j < 4; j++) pop_chk(0, 20'(j), "R3 R5 narrow order");
        chk("R6 empty after drain", {31'h0, val_w[0]}, 0);
        // R12: pops overlapping refills
        for (int j = 4; j < 10; j++) pop_chk(0, 20'(j), "R12 pop with push");

        // R9: wide even reads
        for (int j = 0; j < 6; j++) pop_chk(1, 20'(j), "R9 wide even order");

        // R7: table of flush targets
        for (int v = 0; v < NV; v++) begin
            idle(30);
            do_flush(0, V_TGT[v]);
            chk("R7 flush empties", {31'h0, val_w[0]}, 0);
            for (int j = 0; j < V_POP[v]; j++) pop_chk(0, V_TGT[v] + 20'(j), "R7 R3 after flush");
        end

        // R8: flush while a read is in flight
        idle(10);
        do_flush(0, 20'h00300);
        base = reqs[0];
        wait_req(0, base);
        do_flush(0, 20'h00400);
        base = reqs[0];
        wait_req(0, base);
        chk("R8 redirect address", {12'h0, last_a[0]}, 32'h400);
        for (int j = 0; j < 3; j++) pop_chk(0, 20'h00400 + 20'(j), "R8 stale byte dropped");

        // R5: pop on empty ignored
        idle(20);
        do_flush(0, 20'h00500);
        chk("R5 empty before pop", {31'h0, val_w[0]}, 0);
        pop_s[0] = 1'b1;
        @(negedge clk);
        pop_s[0] = 1'b0;
        pop_chk(0, 20'h00500, "R5 empty pop ignored");
        pop_chk(0, 20'h00501, "R5 empty pop ignored");

        // R10/R11: wide odd target
        idle(5);
        base = reqs[1];
        do_flush(1, 20'h00201);
        wait_req(1, base);
        chk("R10 odd read address", {12'h0, last_a[1]}, 32'h201);
        idle(40);
        chk("R11 one slot left, no read", reqs[1] - base, 3);
        pop_chk(1, 20'h00201, "R10 upper byte only");
        idle(20);
        chk("R11 read after slot freed", reqs[1] - base, 4);
        for (int j = 2; j < 8; j++) pop_chk(1, 20'h00200 + 20'(j), "R10 continue even");

        finish_run();
    end
endmodule